// File: doc/BRIEF.md
# Masked Shift-and-Add Multiply Sequencer

This block issues the command stream that makes a wide array of one-bit column ALUs multiply two unsigned vectors. The operands are stored transposed. Row `base_a + k` holds bit k of operand A for every column, and row `base_b + k` holds bit k of operand B. After a start pulse the sequencer first clears the 2n product rows starting at `base_p`. It then runs one pass for each multiplier bit. A pass latches that bit of B into every column's tag and resets every carry latch. It then walks the multiplicand bits and accumulates each one into the product row at the shifted offset. It ends by storing the leftover carry in the next row up.

The array applies sums and carry stores only in columns whose tag is 1. All columns therefore follow one shared instruction stream, and the multiplier bits only decide which columns take each write. The operand width n is chosen per run, from 2 up to a parameter maximum. Row addresses are 8 bits wide, and the caller keeps the three row ranges inside the array.

The sequencer has five states:
- S_IDLE waits for a valid start and moves to S_CLR.
- S_CLR loops until the last product row is cleared, then moves to S_TAG.
- S_TAG lasts one cycle and moves to S_ADD.
- S_ADD loops over the multiplicand bits, then moves to S_CST.
- S_CST returns to S_TAG while passes remain, otherwise moves to S_DONE.
- S_DONE lasts one cycle and returns to S_IDLE.

Top module: `bsmul_seq`

## Requirements
- R1: A start pulse seen in S_IDLE with `width` between 2 and MAX_W latches width and the three base rows. `busy` rises on the next cycle.
- R2: The first 2n busy cycles issue clear commands (`cmd_op`=1), with `cmd_dst` = base_p+0 up to base_p+2n-1 in ascending order and `cmd_src`=0.
- R3: Each pass i opens with one tag-load command (`cmd_op`=2) reading row `cmd_src`=base_b+i, with `cmd_dst`=0. This command also resets every carry latch.
- R4: Within pass i there follow n accumulate commands (`cmd_op`=3), with `cmd_src`=base_a+j and `cmd_dst`=base_p+i+j for j ascending from 0.
- R5: Each pass ends with a carry-store command (`cmd_op`=4) to `cmd_dst`=base_p+i+n, with `cmd_src`=0.
- R6: Passes run for i = 0 up to n-1 in ascending order.
- R7: When the array gates sums and carry stores by tag, each column's 2n product rows hold A*B once the run ends. The A and B rows are never written.
- R8: `busy` is high for exactly n*n+4n cycles. `done` is high for the single cycle after that, with `busy` low, and is then low again.
- R9: A start pulse while the sequencer is busy has no effect on the command stream or on the end of the run.
- R10: A start pulse with `width` below 2 or above MAX_W is ignored, and the sequencer stays idle.
- R11: Whenever the sequencer is not busy, `cmd_op` is 0 (no operation) and both row fields are 0. After reset, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request pulse |
| width | input | 5 | Operand width n |
| base_a | input | 8 | First row of multiplicand A |
| base_b | input | 8 | First row of multiplier B |
| base_p | input | 8 | First row of the product |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| cmd_op | output | 3 | Array command: 0 none, 1 clear, 2 tag load, 3 accumulate, 4 carry store |
| cmd_src | output | 8 | Row read by the command |
| cmd_dst | output | 8 | Row written by the command |

## Verification
The bench targets the product rows that are preloaded with ones. A sequencer that skipped or shortened the clear phase would leave stale high bits in the results. It also targets columns with a zero multiplier, a zero multiplicand, and all-ones operands at the largest width. A wrong carry-store row, or a missing carry reset between passes, would corrupt the upper product bits there. A second start pulse is placed in the middle of a run; if it were not ignored, the run would restart and the cycle-exact stream comparison would fail. Widths of 1 and 17 are tried as well, and a design that accepted either one would raise `busy`.

// File: rtl/bsmul_pkg.sv
package bsmul_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_CLR = 3'd1,
        OP_TAG = 3'd2,
        OP_ADD = 3'd3,
        OP_CST = 3'd4
    } cmd_op_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CLR,
        S_TAG,
        S_ADD,
        S_CST,
        S_DONE
    } seq_state_t;

    // busy cycles of one run: 2n clears plus n passes of (tag, n adds, carry)
    function automatic int unsigned busy_cycles(input int unsigned n);
        return n * n + 4 * n;
    endfunction

endpackage

// File: rtl/bsmul_fsm.sv
module bsmul_fsm
    import bsmul_pkg::*;
#(
    parameter int WID_W = 5,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [WID_W-1:0] w,
    output logic             idle,
    output logic             busy,
    output logic             done,
    output cmd_op_t          op,
    output logic [CNT_W-1:0] cnt,
    output logic [WID_W-1:0] pass
);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [WID_W-1:0] pass_q, pass_d;
    logic [CNT_W-1:0] clr_last, add_last;

    assign clr_last = CNT_W'({w, 1'b0}) - 1'b1;
    assign add_last = CNT_W'(w) - 1'b1;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pass_d  = pass_q;
        unique case (state_q)
            S_IDLE: begin
                if (go) begin
                    state_d = S_CLR;
                    cnt_d   = '0;
                    pass_d  = '0;
                end
            end
            S_CLR: begin
                if (cnt_q == clr_last) begin
                    state_d = S_TAG;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            S_TAG: begin
                state_d = S_ADD;
                cnt_d   = '0;
            end
            S_ADD: begin
                if (cnt_q == add_last) state_d = S_CST;
                else                   cnt_d   = cnt_q + 1'b1;
            end
            S_CST: begin
                if (pass_q == w - 1'b1) begin
                    state_d = S_DONE;
                end else begin
                    pass_d  = pass_q + 1'b1;
                    state_d = S_TAG;
                end
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            pass_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pass_q  <= pass_d;
        end
    end

    always_comb begin
        idle = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        op   = OP_NOP;
        unique case (state_q)
            S_IDLE: idle = 1'b1;
            S_CLR:  begin busy = 1'b1; op = OP_CLR; end
            S_TAG:  begin busy = 1'b1; op = OP_TAG; end
            S_ADD:  begin busy = 1'b1; op = OP_ADD; end
            S_CST:  begin busy = 1'b1; op = OP_CST; end
            S_DONE: done = 1'b1;
            default: idle = 1'b0;
        endcase
    end

    assign cnt  = cnt_q;
    assign pass = pass_q;

    a_r1_busy_after_go: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go));

    a_r2_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> op == OP_CLR);

    a_r4_tag_then_add: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_TAG |=> op == OP_ADD);

    a_r5_cst_then_tag_or_done: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_CST |=> (op == OP_TAG || done));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/bsmul_addr.sv
module bsmul_addr
    import bsmul_pkg::*;
#(
    parameter int ROW_W = 8,
    parameter int WID_W = 5,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_op_t          op,
    input  logic [CNT_W-1:0] cnt,
    input  logic [WID_W-1:0] pass,
    input  logic [WID_W-1:0] w,
    input  logic [ROW_W-1:0] base_a,
    input  logic [ROW_W-1:0] base_b,
    input  logic [ROW_W-1:0] base_p,
    output logic [ROW_W-1:0] src,
    output logic [ROW_W-1:0] dst
);

    logic [ROW_W-1:0] pass_row;

    assign pass_row = base_p + ROW_W'(pass);

    always_comb begin
        src = '0;
        dst = '0;
        unique case (op)
            OP_CLR: dst = base_p + ROW_W'(cnt);
            OP_TAG: src = base_b + ROW_W'(pass);
            OP_ADD: begin
                src = base_a + ROW_W'(cnt);
                dst = pass_row + ROW_W'(cnt);
            end
            OP_CST:  dst = pass_row + ROW_W'(w);
            default: src = '0;
        endcase
    end

    a_r4_add_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADD && $past(op) == OP_ADD) |->
            (src == ROW_W'($past(src) + 1'b1) && dst == ROW_W'($past(dst) + 1'b1)));

    a_r5_carry_row: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CST && $past(op) == OP_ADD) |-> dst == ROW_W'($past(dst) + 1'b1));

    a_r11_idle_fields: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_NOP |-> (src == '0 && dst == '0));

endmodule

// File: rtl/bsmul_seq.sv
module bsmul_seq
    import bsmul_pkg::*;
#(
    parameter int MAX_W = 16,
    parameter int ROW_W = 8,
    parameter int WID_W = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WID_W-1:0] width,
    input  logic [ROW_W-1:0] base_a,
    input  logic [ROW_W-1:0] base_b,
    input  logic [ROW_W-1:0] base_p,
    output logic             busy,
    output logic             done,
    output logic [2:0]       cmd_op,
    output logic [ROW_W-1:0] cmd_src,
    output logic [ROW_W-1:0] cmd_dst
);

    localparam int CNT_W = $clog2(2 * MAX_W) + 1;
    localparam int CYC_W = $clog2(MAX_W * MAX_W + 4 * MAX_W + 1);

    logic             idle, go, width_ok;
    logic [WID_W-1:0] w_q;
    logic [ROW_W-1:0] a_q, b_q, p_q;
    logic [CNT_W-1:0] cnt;
    logic [WID_W-1:0] pass;
    logic [CYC_W-1:0] cyc_q;
    cmd_op_t          op;

    assign width_ok = (width >= WID_W'(2)) && (width <= WID_W'(MAX_W));
    assign go       = start && idle && width_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= WID_W'(2);
            a_q <= '0;
            b_q <= '0;
            p_q <= '0;
        end else if (go) begin
            w_q <= width;
            a_q <= base_a;
            b_q <= base_b;
            p_q <= base_p;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cyc_q <= '0;
        else if (go)   cyc_q <= '0;
        else if (busy) cyc_q <= cyc_q + 1'b1;
    end

    bsmul_fsm #(.WID_W(WID_W), .CNT_W(CNT_W)) u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (go),
        .w    (w_q),
        .idle (idle),
        .busy (busy),
        .done (done),
        .op   (op),
        .cnt  (cnt),
        .pass (pass)
    );

    bsmul_addr #(.ROW_W(ROW_W), .WID_W(WID_W), .CNT_W(CNT_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .cnt   (cnt),
        .pass  (pass),
        .w     (w_q),
        .base_a(a_q),
        .base_b(b_q),
        .base_p(p_q),
        .src   (cmd_src),
        .dst   (cmd_dst)
    );

    assign cmd_op = op;

    a_r8_cycle_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cyc_q == CYC_W'(busy_cycles(32'(w_q))));

    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(w_q));

    a_r10_bad_width_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && !width_ok) |=> !busy);

endmodule

// File: tb/sim_bsmul_seq.sv
module sim_bsmul_seq;

    localparam int COLS = 8;
    localparam int ROWS = 256;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, start;
    logic [4:0] width;
    logic [7:0] base_a, base_b, base_p;
    logic       busy, done;
    logic [2:0] cmd_op;
    logic [7:0] cmd_src, cmd_dst;

    bsmul_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .width(width),
        .base_a(base_a), .base_b(base_b), .base_p(base_p),
        .busy(busy), .done(done), .cmd_op(cmd_op),
        .cmd_src(cmd_src), .cmd_dst(cmd_dst)
    );

    int checks = 0;
    int errors = 0;

    logic [COLS-1:0] mem [ROWS];
    logic [COLS-1:0] tag, carry;
    longint va [COLS];
    longint vb [COLS];
    logic [18:0] expq [$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural column array: gated by per-column tag
    task automatic exec_cmd();
        case (cmd_op)
            3'd1: mem[cmd_dst] = '0;
            3'd2: begin tag = mem[cmd_src]; carry = '0; end
            3'd3: begin
                for (int c = 0; c < COLS; c++) begin
                    if (tag[c]) begin
                        logic a, p, s;
                        a = mem[cmd_src][c];
                        p = mem[cmd_dst][c];
                        s = a ^ p ^ carry[c];
                        carry[c] = (a & p) | (carry[c] & (a ^ p));
                        mem[cmd_dst][c] = s;
                    end
                end
            end
            3'd4: begin
                for (int c = 0; c < COLS; c++)
                    if (tag[c]) mem[cmd_dst][c] = carry[c];
            end
            default: ;
        endcase
    endtask

    function automatic longint pick(input int seed, input int c);
        logic [31:0] x;
        x = 32'(seed * 1103 + c * 7919 + c * c * 31 + 17);
        x = x ^ (x >> 5) ^ (x << 3);
        return longint'(x);
    endfunction

    task automatic run_mul(input int w, input int ba, input int bb, input int bp,
                           input int seed, input bit poke);
        longint mask;
        int n;
        logic [COLS-1:0] snap [64];
        mask = (longint'(1) << w) - 1;
        for (int c = 0; c < COLS; c++) begin
            va[c] = pick(seed, c) & mask;
            vb[c] = pick(seed + 3, c + 11) & mask;
        end
        va[0] = mask; vb[0] = mask;
        vb[1] = 0;
        va[2] = 0;
        va[3] = 1;
        for (int k = 0; k < w; k++) begin
            for (int c = 0; c < COLS; c++) begin
                mem[8'(ba + k)][c] = va[c][k];
                mem[8'(bb + k)][c] = vb[c][k];
            end
        end
        for (int k = 0; k < 2 * w; k++) mem[8'(bp + k)] = '1;
        for (int k = 0; k < w; k++) begin
            snap[k]      = mem[8'(ba + k)];
            snap[k + 32] = mem[8'(bb + k)];
        end
        expq.delete();
        for (int k = 0; k < 2 * w; k++) expq.push_back({3'd1, 8'd0, 8'(bp + k)});
        for (int i = 0; i < w; i++) begin
            expq.push_back({3'd2, 8'(bb + i), 8'd0});
            for (int j = 0; j < w; j++) expq.push_back({3'd3, 8'(ba + j), 8'(bp + i + j)});
            expq.push_back({3'd4, 8'd0, 8'(bp + i + w)});
        end

        @(negedge clk);
        start = 1'b1; width = 5'(w);
        base_a = 8'(ba); base_b = 8'(bb); base_p = 8'(bp);
        n = 0;
        while (expq.size() > 0) begin
            logic [18:0] e;
            string req;
            @(negedge clk);
            start = poke && (n == 5);
            width = (poke && n == 5) ? 5'd4 : 5'(w);
            e = expq.pop_front();
            case (e[18:16])
                3'd1: req = "R2";
                3'd2: req = "R3 R6";
                3'd3: req = "R4";
                default: req = "R5";
            endcase
            if (poke && n > 5) req = {req, " R9"};
            check(busy && !done, "R8", "busy during run", longint'({busy, done}), 2);
            check({cmd_op, cmd_src, cmd_dst} == e, req, "command",
                  longint'({cmd_op, cmd_src, cmd_dst}), longint'(e));
            exec_cmd();
            n++;
        end
        start = 1'b0;
        check(n == w * w + 4 * w, "R8", "busy cycle count", n, w * w + 4 * w);
        @(negedge clk);
        check(done && !busy, "R8", "done pulse", longint'({busy, done}), 1);
        check(cmd_op == 3'd0 && cmd_src == 8'd0 && cmd_dst == 8'd0, "R11",
              "idle command", longint'({cmd_op, cmd_src, cmd_dst}), 0);
        @(negedge clk);
        check(!done && !busy, "R8 R9", "after done", longint'({busy, done}), 0);
        for (int c = 0; c < COLS; c++) begin
            longint prod;
            prod = 0;
            for (int k = 0; k < 2 * w; k++)
                prod = prod | (longint'(mem[8'(bp + k)][c]) << k);
            check(prod == va[c] * vb[c], "R7", $sformatf("product col %0d w %0d", c, w),
                  prod, va[c] * vb[c]);
        end
        for (int k = 0; k < w; k++) begin
            check(mem[8'(ba + k)] == snap[k] && mem[8'(bb + k)] == snap[k + 32], "R7",
                  "operand rows untouched", longint'(mem[8'(ba + k)]), longint'(snap[k]));
        end
    endtask

    task automatic try_bad(input int w);
        @(negedge clk);
        start = 1'b1; width = 5'(w);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check(!busy && cmd_op == 3'd0, "R10", $sformatf("width %0d ignored", w),
                  longint'({busy, cmd_op}), 0);
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished run");
        finish_run();
    end

    initial begin
        for (int r = 0; r < ROWS; r++) mem[r] = '0;
        tag = '0; carry = '0;
        rst_n = 1'b0; start = 1'b0; width = 5'd2;
        base_a = '0; base_b = '0; base_p = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R11", "reset flags", longint'({busy, done}), 0);
        check(cmd_op == 3'd0 && cmd_src == 8'd0 && cmd_dst == 8'd0, "R11",
              "reset command", longint'({cmd_op, cmd_src, cmd_dst}), 0);

        run_mul(2, 0, 2, 4, 1, 1'b0);
        run_mul(3, 10, 20, 30, 2, 1'b0);
        try_bad(1);
        run_mul(8, 100, 120, 140, 3, 1'b1);
        try_bad(17);
        run_mul(16, 200, 216, 0, 4, 1'b0);
        run_mul(5, 60, 70, 250, 5, 1'b0);
        finish_run();
    end

endmodule